// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor load/store port and a word-wide main memory. It holds one word per line in a direct-mapped array. Each line keeps a valid flag, a modified flag, a tag and the data word. Store hits change only the cached copy and mark the line modified. Memory is brought up to date only when that line is evicted: a miss that falls on a modified line first pushes the old word out to its own address, and only then fetches the new one.

A static configuration input decides what a store miss does. With `alloc_on_write` low, the store goes straight to memory and the array is left alone. With it high, the store data is placed in the line, which is then marked modified.

The processor holds a request, with its address and data, until `cpu_stall` is low on a clock edge; the access completes on that edge. The memory port holds a request until `mem_ready` is high on an edge.

Top module: `wb_cache_ctrl`

## Requirements
- R1: A store that hits completes in its first cycle (`cpu_stall` low), changes the cached word, and issues no memory transaction.
- R2: A store hit marks the line modified, so a later eviction of that line writes the stored value to memory.
- R3: A load that hits a modified line returns the updated value in its first cycle with no memory transaction.
- R4: A miss on a valid modified line makes two memory transactions in order: first a write of the old word to the address formed as {stored tag, index}, then a read of the requested address.
- R5: A load miss on an invalid or unmodified line makes exactly one memory transaction, a read of the requested address, and returns the word read.
- R6: With `alloc_on_write`=0, a store miss makes one memory write of the store data to the store address and leaves the cache contents unchanged.
- R7: With `alloc_on_write`=1, a store miss makes no memory read, installs the store data in the line (after writing back a modified victim), and leaves that line modified.
- R8: A line filled by a read starts unmodified, so evicting it makes no writeback.
- R9: `cpu_stall` is low only on an idle cycle whose request hits (or when there is no request) and on the single response cycle that ends a miss. A pending memory request keeps its address, direction and data until `mem_ready`.
- R10: After reset every line is invalid, `cpu_stall` is low with no request, and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_on_write | input | 1 | Store-miss policy: 1 allocate, 0 write-around |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when `cpu_stall` is low |
| cpu_stall | output | 1 | High while the access is still in progress |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the transaction this cycle |

## Verification
The bench builds the controller with an 8-bit address, a 16-bit data word and two index bits, so there are four lines. With so few lines, two addresses that differ only in their tag land on the same line. Conflict evictions of modified and unmodified victims can then be set up in a handful of accesses. The memory model answers after a fixed wait, which makes the stall length of each miss kind an exact number the bench can predict. The small address space lets the bench mirror the whole memory and check that written-back words reach it.

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_on_write,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_WBACK, S_FILL, S_WARD, S_RESP} state_t;

  state_t             st_q, st_d;
  logic [LINES-1:0]   valid_q, dirty_q;
  logic [TAG_W-1:0]   tag_q  [LINES];
  logic [DATA_W-1:0]  data_q [LINES];

  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic               hit, victim_dirty, mem_done;
  logic               ln_we, ln_dirty;
  logic [DATA_W-1:0]  ln_data;

  assign idx          = cpu_addr[IDX_W-1:0];
  assign tag          = cpu_addr[ADDR_W-1:IDX_W];
  assign hit          = valid_q[idx] && (tag_q[idx] == tag);
  assign victim_dirty = valid_q[idx] && dirty_q[idx];
  assign mem_done     = mem_req && mem_ready;

  always_comb begin
    st_d     = st_q;
    ln_we    = 1'b0;
    ln_data  = cpu_wdata;
    ln_dirty = 1'b1;
    case (st_q)
      S_IDLE: if (cpu_req) begin
        if (hit) begin
          ln_we = cpu_we;
        end else if (cpu_we && !alloc_on_write) begin
          st_d = S_WARD;
        end else if (victim_dirty) begin
          st_d = S_WBACK;
        end else if (cpu_we) begin
          ln_we = 1'b1;
          st_d  = S_RESP;
        end else begin
          st_d = S_FILL;
        end
      end
      S_WBACK: if (mem_done) begin
        if (cpu_we) begin
          ln_we = 1'b1;
          st_d  = S_RESP;
        end else begin
          st_d = S_FILL;
        end
      end
      S_FILL: if (mem_done) begin
        ln_we    = 1'b1;
        ln_data  = mem_rdata;
        ln_dirty = 1'b0;
        st_d     = S_RESP;
      end
      S_WARD: if (mem_done) st_d = S_RESP;
      S_RESP: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      st_q <= st_d;
      if (ln_we) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= ln_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ln_we) begin
      tag_q[idx]  <= tag;
      data_q[idx] <= ln_data;
    end
  end

  assign cpu_rdata = data_q[idx];
  assign cpu_stall = !(((st_q == S_IDLE) && (!cpu_req || hit)) || (st_q == S_RESP));
  assign mem_req   = (st_q == S_WBACK) || (st_q == S_FILL) || (st_q == S_WARD);
  assign mem_we    = (st_q != S_FILL);
  assign mem_addr  = (st_q == S_WBACK) ? {tag_q[idx], idx} : cpu_addr;
  assign mem_wdata = (st_q == S_WBACK) ? data_q[idx] : cpu_wdata;
endmodule

// File: rtl/wb_cache_chk.sv
module wb_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_on_write,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);
  p_hit_nomem_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |-> !mem_req);

  p_wb_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));

  p_read_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == cpu_addr));

  p_around_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !alloc_on_write && mem_req) |->
      (mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata));

  p_alloc_noread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && alloc_on_write && mem_req) |-> mem_we);

  p_fill_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && mem_req && !mem_we && mem_ready) |=> !cpu_stall);

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind wb_cache_ctrl wb_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_on_write(alloc_on_write),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/tb_wb_cache_ctrl.sv
module tb_wb_cache_ctrl;
  localparam int AW = 8, DW = 16, IW = 2;

  logic          clk = 1'b0, rst_n = 1'b0, alloc_on_write = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, mem_wdata, mem_rdata;
  logic          cpu_stall, mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  wb_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_on_write(alloc_on_write),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  logic [DW-1:0] mem [256];
  int            wcnt;
  int            tx_n;
  logic          tx_we [32];
  logic [AW-1:0] tx_a  [32];
  logic [DW-1:0] tx_d  [32];

  assign mem_ready = mem_req && (wcnt == 2);
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (rst_n && mem_req && mem_ready) begin
      if (tx_n < 32) begin
        tx_we[tx_n] <= mem_we;
        tx_a[tx_n]  <= mem_addr;
        tx_d[tx_n]  <= mem_wdata;
      end
      tx_n <= tx_n + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
    end
  end

  int total = 0, bad = 0;
  logic finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cyc = 0;
    forever begin
      #1;
      cyc++;
      if (!cpu_stall || cyc > 100) break;
      @(negedge clk);
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
  endtask

  localparam logic [AW-1:0] A = 8'h10, B = 8'h20;
  logic [DW-1:0] rd;
  int cyc, n0;

  task automatic t_reset();
    @(negedge clk);
    chk(cpu_stall == 1'b0, "R10 stall", int'(cpu_stall), 0);
    chk(mem_req == 1'b0, "R10 mem_req", int'(mem_req), 0);
    n0 = tx_n;
    access(1'b0, A, '0, rd, cyc);
    chk(tx_n - n0 == 1 && !tx_we[n0] && tx_a[n0] == A, "R10 first load misses", tx_n - n0, 1);
    chk(rd == 16'h1010, "R5 fill data", rd, 16'h1010);
    chk(cyc == 5, "R9 clean miss stall", cyc, 5);
  endtask

  task automatic t_store_hit();
    n0 = tx_n;
    access(1'b1, A, 16'hBEEF, rd, cyc);
    chk(cyc == 1, "R1 store hit one cycle", cyc, 1);
    chk(tx_n == n0, "R1 store hit no memory", tx_n - n0, 0);
    chk(mem[A] == 16'h1010, "R1 memory stale", mem[A], 16'h1010);
    access(1'b0, A, '0, rd, cyc);
    chk(rd == 16'hBEEF && cyc == 1 && tx_n == n0, "R3 dirty load hit", rd, 16'hBEEF);
  endtask

  task automatic t_dirty_evict();
    n0 = tx_n;
    access(1'b0, B, '0, rd, cyc);
    chk(tx_n - n0 == 2, "R4 two transactions", tx_n - n0, 2);
    chk(tx_we[n0] && tx_a[n0] == A && tx_d[n0] == 16'hBEEF, "R4 writeback first", tx_a[n0], A);
    chk(!tx_we[n0+1] && tx_a[n0+1] == B, "R4 read second", tx_a[n0+1], B);
    chk(mem[A] == 16'hBEEF, "R2 stored value reached memory", mem[A], 16'hBEEF);
    chk(rd == 16'h1020, "R4 load data", rd, 16'h1020);
    chk(cyc == 8, "R9 dirty miss stall", cyc, 8);
  endtask

  task automatic t_clean_evict();
    n0 = tx_n;
    access(1'b0, A, '0, rd, cyc);
    chk(tx_n - n0 == 1 && !tx_we[n0], "R8 refilled line evicted without writeback", tx_n - n0, 1);
    chk(rd == 16'hBEEF, "R5 read returns memory word", rd, 16'hBEEF);
  endtask

  task automatic t_write_around();
    alloc_on_write = 1'b0;
    n0 = tx_n;
    access(1'b1, B, 16'h5555, rd, cyc);
    chk(tx_n - n0 == 1 && tx_we[n0] && tx_a[n0] == B && tx_d[n0] == 16'h5555,
        "R6 single memory write", tx_d[n0], 16'h5555);
    chk(cyc == 5, "R9 write-around stall", cyc, 5);
    n0 = tx_n;
    access(1'b0, A, '0, rd, cyc);
    chk(rd == 16'hBEEF && cyc == 1 && tx_n == n0, "R6 cache untouched", rd, 16'hBEEF);
    access(1'b0, B, '0, rd, cyc);
    chk(tx_n - n0 == 1 && !tx_we[n0] && rd == 16'h5555, "R6 later load reads memory", rd, 16'h5555);
  endtask

  task automatic t_allocate();
    alloc_on_write = 1'b1;
    n0 = tx_n;
    access(1'b1, A, 16'h7777, rd, cyc);
    chk(tx_n == n0 && cyc == 2, "R7 clean-victim allocate, no memory", cyc, 2);
    access(1'b0, A, '0, rd, cyc);
    chk(rd == 16'h7777 && cyc == 1 && tx_n == n0, "R7 allocated data hits", rd, 16'h7777);
    access(1'b1, B, 16'h3333, rd, cyc);
    chk(tx_n - n0 == 1 && tx_we[n0] && tx_a[n0] == A && tx_d[n0] == 16'h7777,
        "R7 allocated line was dirty", tx_d[n0], 16'h7777);
    n0 = tx_n;
    access(1'b0, A, '0, rd, cyc);
    chk(tx_n - n0 == 2 && tx_we[n0] && tx_a[n0] == B && tx_d[n0] == 16'h3333,
        "R7 dirty-victim allocate kept dirty", tx_d[n0], 16'h3333);
    chk(rd == 16'h7777, "R7 memory copy", rd, 16'h7777);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + i[15:0];
    tx_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_store_hit();
    t_dirty_evict();
    t_clean_evict();
    t_write_around();
    t_allocate();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule